// File: doc/BRIEF.md
# Split-Section Decade Counter

This block is a four-bit counter made of two sections that run independently. The low section is a single toggle stage that halves the rate of its count input. Its state is bit 0 of the output. The high section is a modulo-5 stage with its own count input. Its three state bits are bits 3..1 of the output, with bit 1 as the least significant. Both count inputs are asynchronous levels. Each passes through a synchronizer clocked by the free-running system clock. A section advances only when its synchronized input goes from 1 to 0.

Two gating pairs override counting. When both clear pins are high, the output goes to zero. When both preset pins are high, the output goes to nine (binary 1001), and this happens whether or not the clear pair is active. A chain-mode pin feeds the low section's 1-to-0 carry into the high section. With chain mode set, the block counts in BCD from a single input and needs no external wiring. There is no data stream, so every pin is a plain control or status level.

Top module: `split_decade_counter`

## Requirements
- R1: While rst_n is low the output is 0. After release, no step occurs unless a count input actually falls, even if the count inputs were high during reset.
- R2: Each 1-to-0 transition of cnt_a_in inverts q_out[0]. A 0-to-1 transition changes nothing. Each level must be held for at least two clock cycles.
- R3: With chain_en low, each 1-to-0 transition of cnt_b_in moves q_out[3:1] (bit 1 = LSB) through 0,1,2,3,4 and back to 0. q_out[0] is not affected.
- R4: With chain_en high, the high section advances in the same cycle that a counted A edge takes q_out[0] from 1 to 0. q_out then runs 0..9 in BCD and wraps to 0, and cnt_b_in is ignored.
- R5: When clr_a and clr_b are both high and the preset pair is not, q_out is 0 from the next rising clock edge on, for as long as the condition holds.
- R6: When nine_a and nine_b are both high, q_out is 4'b1001 from the next rising clock edge on, whatever the clear pins are.
- R7: A falling count edge that is detected while a clear or preset condition holds is discarded. After release, the output keeps the forced value.
- R8: Assume an input fall is set up before rising edge E1. With the default two synchronizer stages, the output changes at rising edge E3 and not before.
- R9: q_out[3:1] never holds 5, 6 or 7. If such a state were ever present, the next high-section step would return it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample all inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_a_in | input | 1 | Count input of the toggle section, counts on its falling edge |
| cnt_b_in | input | 1 | Count input of the modulo-5 section, used when chain_en is low |
| chain_en | input | 1 | 1: the high section is clocked by the low section's carry |
| clr_a | input | 1 | Clear gate, first input of the AND |
| clr_b | input | 1 | Clear gate, second input of the AND |
| nine_a | input | 1 | Preset-to-nine gate, first input of the AND |
| nine_b | input | 1 | Preset-to-nine gate, second input of the AND |
| q_out | output | 4 | Counter state: bit 0 from the toggle section, bits 3..1 from the modulo-5 section |

## Verification
The clear and preset conditions can hold in the same cycle. The bench raises all four gating pins together and expects nine, which shows that preset wins. A count edge can also be detected in a cycle where an override holds. The bench lets a count input fall while clear or preset is held, keeps the gate on past the synchronizer delay, then releases it. It judges the case by checking that the forced value is unchanged. In chain mode, the carry of the low section and the step of the high section occur in one cycle. This is judged at every wrap from 9 to 0.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [1:0] {
    GATE_COUNT = 2'd0,
    GATE_CLEAR = 2'd1,
    GATE_NINE  = 2'd2
  } gate_e;

  // Preset outranks clear; otherwise the sections count.
  function automatic gate_e gate_decode(input logic clr_a, input logic clr_b,
                                        input logic nine_a, input logic nine_b);
    if (nine_a && nine_b)      return GATE_NINE;
    else if (clr_a && clr_b)   return GATE_CLEAR;
    else                       return GATE_COUNT;
  endfunction

endpackage

// File: rtl/sdc_edge_sync.sv
module sdc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic fall_o
);

  logic sync_q [STAGES];
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= din;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  endgenerate

  // Reset to 0 so a high input at reset is seen as a rise, never a fall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sync_q[STAGES-1];

endmodule

// File: rtl/sdc_toggle_stage.sv
module sdc_toggle_stage
  import sdc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  gate_e gate,
  input  logic  adv,
  output logic  q,
  output logic  carry_o
);

  logic q_next;

  always_comb begin
    unique case (gate)
      GATE_NINE:  q_next = 1'b1;
      GATE_CLEAR: q_next = 1'b0;
      default:    q_next = adv ? ~q : q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_next;
  end

  // Counted 1-to-0 step of this stage.
  assign carry_o = (gate == GATE_COUNT) & adv & q;

endmodule

// File: rtl/sdc_modn_stage.sv
module sdc_modn_stage
  import sdc_pkg::*;
#(
  parameter int MOD        = 5,
  parameter int W          = $clog2(MOD),
  parameter int PRESET_VAL = MOD - 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  gate_e        gate,
  input  logic         adv,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] LAST = W'(MOD - 1);
  localparam logic [W-1:0] PRE  = W'(PRESET_VAL);

  logic [W-1:0] q_next;
  logic [W-1:0] q_step;

  // Last legal state and every illegal state fall back to zero.
  assign q_step = (q >= LAST) ? '0 : q + W'(1);

  always_comb begin
    unique case (gate)
      GATE_NINE:  q_next = PRE;
      GATE_CLEAR: q_next = '0;
      default:    q_next = adv ? q_step : q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

endmodule

// File: rtl/split_decade_counter.sv
module split_decade_counter
  import sdc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HI_MOD      = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cnt_a_in,
  input  logic                     cnt_b_in,
  input  logic                     chain_en,
  input  logic                     clr_a,
  input  logic                     clr_b,
  input  logic                     nine_a,
  input  logic                     nine_b,
  output logic [$clog2(HI_MOD):0]  q_out
);

  localparam int HI_W = $clog2(HI_MOD);

  gate_e             gate;
  logic              a_fall;
  logic              b_fall;
  logic              a_carry;
  logic              hi_adv;
  logic              lo_q;
  logic [HI_W-1:0]   hi_q;

  assign gate = gate_decode(clr_a, clr_b, nine_a, nine_b);

  sdc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
    .clk(clk), .rst_n(rst_n), .din(cnt_a_in), .fall_o(a_fall)
  );

  sdc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
    .clk(clk), .rst_n(rst_n), .din(cnt_b_in), .fall_o(b_fall)
  );

  sdc_toggle_stage u_lo (
    .clk(clk), .rst_n(rst_n), .gate(gate), .adv(a_fall),
    .q(lo_q), .carry_o(a_carry)
  );

  assign hi_adv = chain_en ? a_carry : b_fall;

  sdc_modn_stage #(.MOD(HI_MOD), .W(HI_W), .PRESET_VAL(HI_MOD - 1)) u_hi (
    .clk(clk), .rst_n(rst_n), .gate(gate), .adv(hi_adv), .q(hi_q)
  );

  assign q_out = {hi_q, lo_q};

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int QW     = 4,
  parameter int HI_MAX = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chain_en,
  input logic          clr_a,
  input logic          clr_b,
  input logic          nine_a,
  input logic          nine_b,
  input logic [QW-1:0] q_out
);

  localparam int BW = QW - 1;
  localparam logic [BW-1:0] HMAX = BW'(HI_MAX);

  logic ovr;
  logic nine_on;
  logic clr_on;
  assign nine_on = nine_a & nine_b;
  assign clr_on  = clr_a & clr_b;
  assign ovr     = nine_on | clr_on;

  p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    nine_on |=> (q_out == QW'(9)));

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_on && !nine_on) |=> (q_out == '0));

  p_hi_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    q_out[QW-1:1] <= HMAX);

  p_hi_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ovr) && (q_out[QW-1:1] != $past(q_out[QW-1:1]))) |->
      (q_out[QW-1:1] == (($past(q_out[QW-1:1]) == HMAX) ? '0
                          : $past(q_out[QW-1:1]) + BW'(1))));

  p_chain_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chain_en) && !$past(ovr) && (q_out[QW-1:1] != $past(q_out[QW-1:1])))
      |-> $fell(q_out[0]));

endmodule

bind split_decade_counter sdc_checker u_chk (
  .clk(clk), .rst_n(rst_n), .chain_en(chain_en),
  .clr_a(clr_a), .clr_b(clr_b), .nine_a(nine_a), .nine_b(nine_b),
  .q_out(q_out)
);

// File: tb/split_decade_counter_tb.sv
module split_decade_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_a_in = 1'b1;
  logic       cnt_b_in = 1'b1;
  logic       chain_en = 1'b0;
  logic       clr_a = 1'b0;
  logic       clr_b = 1'b0;
  logic       nine_a = 1'b0;
  logic       nine_b = 1'b0;
  logic [3:0] q_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  split_decade_counter u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_a_in(cnt_a_in), .cnt_b_in(cnt_b_in),
    .chain_en(chain_en), .clr_a(clr_a), .clr_b(clr_b),
    .nine_a(nine_a), .nine_b(nine_b), .q_out(q_out)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_a();
    cnt_a_in = 1'b0; idle(4);
    cnt_a_in = 1'b1; idle(4);
  endtask

  task automatic pulse_b();
    cnt_b_in = 1'b0; idle(4);
    cnt_b_in = 1'b1; idle(4);
  endtask

  task automatic do_clear();
    clr_a = 1'b1; clr_b = 1'b1; idle(1);
    clr_a = 1'b0; clr_b = 1'b0; idle(1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle(3);
    check("R1 during reset", q_out, 4'd0);
    rst_n = 1'b1; idle(6);
    check("R1 no spurious step", q_out, 4'd0);
  endtask

  task automatic t_toggle_latency();
    cnt_a_in = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check("R8 unchanged after second edge", q_out, 4'd0);
    @(posedge clk); @(negedge clk);
    check("R8 changed at third edge", q_out, 4'd1);
    idle(2);
    cnt_a_in = 1'b1; idle(5);
    check("R2 rising edge ignored", q_out, 4'd1);
    pulse_a();
    check("R2 second fall toggles back", q_out, 4'd0);
  endtask

  task automatic t_hi_mod5();
    chain_en = 1'b0;
    do_clear();
    for (int i = 1; i <= 7; i++) begin
      pulse_b();
      check("R3 modulo-5 step", q_out, 4'((i % 5) << 1));
    end
    pulse_a();
    check("R3 low bit independent of B", q_out, 4'b0101);
  endtask

  task automatic t_chain();
    do_clear();
    chain_en = 1'b1;
    pulse_b();
    check("R4 cnt_b_in ignored in chain", q_out, 4'd0);
    for (int i = 1; i <= 12; i++) begin
      pulse_a();
      check("R4 BCD sequence", q_out, 4'(i % 10));
    end
    chain_en = 1'b0;
  endtask

  task automatic t_clear();
    do_clear();
    pulse_a(); pulse_b(); pulse_b();
    check("R5 setup nonzero", q_out, 4'b0101);
    clr_a = 1'b1; clr_b = 1'b1; idle(1);
    check("R5 clear forces zero", q_out, 4'd0);
    clr_a = 1'b0; idle(1);
    pulse_a();
    check("R5 single clear pin counts", q_out, 4'd1);
    clr_b = 1'b0;
  endtask

  task automatic t_preset_priority();
    do_clear();
    clr_a = 1'b1; clr_b = 1'b1; nine_a = 1'b1; nine_b = 1'b1; idle(1);
    check("R6 preset beats clear", q_out, 4'b1001);
    nine_b = 1'b0; idle(1);
    check("R5 clear after preset drops", q_out, 4'd0);
    clr_a = 1'b0; clr_b = 1'b0; nine_a = 1'b0; idle(1);
  endtask

  task automatic t_ignore();
    do_clear();
    clr_a = 1'b1; clr_b = 1'b1;
    cnt_a_in = 1'b0; idle(6);
    cnt_a_in = 1'b1; idle(4);
    clr_a = 1'b0; clr_b = 1'b0; idle(4);
    check("R7 A fall under clear dropped", q_out, 4'd0);
    nine_a = 1'b1; nine_b = 1'b1;
    cnt_b_in = 1'b0; idle(6);
    cnt_b_in = 1'b1; idle(4);
    nine_a = 1'b0; nine_b = 1'b0; idle(4);
    check("R7 B fall under preset dropped", q_out, 4'b1001);
    pulse_b();
    check("R9 hi wraps from 4 to 0", q_out, 4'b0001);
  endtask

  initial begin
    t_reset();
    t_toggle_latency();
    t_hi_mod5();
    t_chain();
    t_clear();
    t_preset_priority();
    t_ignore();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

endmodule